// File: doc/BRIEF.md
# Selectable Video Sync Generator

The block derives raster timing from a pixel clock for a fixed family of SD and HD video formats and presents it on a 3-bit status bus. A mode input chooses between two output conventions. One is consumer-display sync: horizontal sync, vertical sync and a data-enable strobe. The other is broadcast-style flags: horizontal blanking, vertical blanking and field identity. A format code picks the raster. For the 525-line interlaced format, a control bit widens the vertical data-enable window. The wider window matches the vertical blanking that the embedded timing reference words of that format define.

Pixel and line counters run continuously. The format code, the mode and the window bit are captured only when the counters wrap from the last pixel of the last line. A change therefore never breaks a frame part-way through. A parameter divides every horizontal interval by an integer, with a floor of one pixel, so that short rasters are available for fast simulation. Vertical counts are never scaled.

Top module: `cea_sync_gen`

## Requirements
- R1: When the captured mode is 1, stat[2] is DE, stat[1] is VSYNC and stat[0] is HSYNC. When it is 0, stat[2] is the field flag, stat[1] is the vertical-blanking flag and stat[0] is the horizontal-blanking flag. All three flags are active-high. The horizontal-blanking flag is high on every pixel outside the active pixel window.
- R2: Each line starts with HSYNC at pixel 0, then back porch, then active pixels, then front porch. The (total, active, sync, back porch) values per code are: 0 = 480i (858,720,62,57) over 525 lines; 1 = 576i (864,720,63,69) over 625; 2 = 720p60 (1650,1280,40,220) over 750; 3 = 720p50 (1980,1280,40,220) over 750; 4 = 1080i60 and 6 = 1080p30/60 (2200,1920,44,148) over 1125; 5 = 1080i50 and 7 = 1080p25/50 (2640,1920,44,148) over 1125; 8 = 1080p24 (2750,1920,44,148) over 1125. Each horizontal value becomes max(1, value / H_DIV).
- R3: HSYNC and VSYNC are active-low for codes 0 and 1 and active-high for all HD codes. DE is always active-high.
- R4: For 480i with the window bit low, DE is active on lines 22 to 261 and 285 to 524, which is 480 lines.
- R5: For 480i with the window bit high, DE is active on lines 20 to 263 and 283 to 525, which is 487 lines. The window bit has no effect on any other format.
- R6: DE is active on these lines. 576i: 23 to 310 and 336 to 623. 720p: 26 to 745. 1080i: 21 to 560 and 584 to 1123. 1080p: 42 to 1121.
- R7: The first-field VSYNC covers whole lines: lines 4 to 6 for 480i, 1 to 3 for 576i, and 1 to 5 for HD. In interlaced formats the second-field VSYNC starts at pixel total/2 of line 266 (480i), 313 (576i) or 563 (1080i). It lasts the same number of lines and ends at pixel total/2.
- R8: DE is the AND of the horizontal and vertical active windows, and it is never high while HSYNC or VSYNC is active.
- R9: Changes to the format code, the mode or the window bit take effect only at the first pixel of line 1 of the next frame.
- R10: While reset is low, stat is 000 and the counters sit at line 1, pixel 0 with the inputs captured. The stat for line 1, pixel 0 appears one clock after reset is released.
- R11: The field flag is high from line 264 (480i), 313 (576i) or 563 (1080i) to the end of the frame. It is always low for progressive formats.
- R12: Format codes 9 to 15 give the 480i timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cea_mode | input | 1 | 1 selects sync/DE outputs, 0 selects blanking/field flags |
| fmt_sel | input | 4 | Raster format code |
| trs_follow | input | 1 | 1 selects the wider 480i vertical DE window |
| stat | output | 3 | Registered status bus |

## Verification
A behavioural reference model is compared against the status bus on every clock. It is driven through a sequence of frames, and each frame isolates one behaviour.

- Two consecutive 480i frames, with the window bit changed half-way through the first, show the 480-line and 487-line windows. They also show that the mid-frame change waits for the frame boundary.
- A 480i frame in flag mode, selected with an unused format code, separates the field and blanking flags from the sync convention and confirms the fallback for unused codes.
- A 576i frame with the window bit high shows that the bit does not leak into other formats.
- A 1080i frame exposes the half-line position of the second VSYNC and the active-high HD polarity.
- A partial 720p frame covers a progressive raster.

// File: rtl/cea_sync_pkg.sv
// Shared widths, format codes and record types for the sync generator.
package cea_sync_pkg;
    parameter int PIX_W  = 12;
    parameter int LINE_W = 11;
    parameter int FMT_W  = 4;

    localparam logic [FMT_W-1:0] FMT_480I    = 4'd0;
    localparam logic [FMT_W-1:0] FMT_576I    = 4'd1;
    localparam logic [FMT_W-1:0] FMT_720P60  = 4'd2;
    localparam logic [FMT_W-1:0] FMT_720P50  = 4'd3;
    localparam logic [FMT_W-1:0] FMT_1080I60 = 4'd4;
    localparam logic [FMT_W-1:0] FMT_1080I50 = 4'd5;
    localparam logic [FMT_W-1:0] FMT_1080P60 = 4'd6;
    localparam logic [FMT_W-1:0] FMT_1080P50 = 4'd7;
    localparam logic [FMT_W-1:0] FMT_1080P24 = 4'd8;

    // User controls, captured once per frame
    typedef struct packed {
        logic [FMT_W-1:0] fmt;
        logic             cea;
        logic             trs;
    } ctrl_t;

    // Decoded raster geometry; horizontal ends exclusive, vertical active ends inclusive
    typedef struct packed {
        logic [PIX_W-1:0]  ht;
        logic [PIX_W-1:0]  hs_end;
        logic [PIX_W-1:0]  act_beg;
        logic [PIX_W-1:0]  act_end;
        logic [PIX_W-1:0]  half;
        logic [LINE_W-1:0] vt;
        logic [LINE_W-1:0] vs1_beg;
        logic [LINE_W-1:0] vs1_end;
        logic [LINE_W-1:0] vs2_beg;
        logic [LINE_W-1:0] vs2_end;
        logic [LINE_W-1:0] a1_beg;
        logic [LINE_W-1:0] a1_end;
        logic [LINE_W-1:0] a2_beg;
        logic [LINE_W-1:0] a2_end;
        logic [LINE_W-1:0] f2_beg;
        logic              interlaced;
        logic              neg_pol;
    } raster_t;

    // Horizontal interval after division, never below one pixel
    function automatic int hscale(input int n, input int div);
        return ((n / div) < 1) ? 1 : (n / div);
    endfunction
endpackage

// File: rtl/cea_fmt_decode.sv
// Format decoder: maps the captured controls to raster geometry.
// Assumes H_DIV >= 1; codes above 8 fall back to 480i.
module cea_fmt_decode
    import cea_sync_pkg::*;
#(
    parameter int H_DIV = 1
) (
    input  ctrl_t   ctrl,
    output raster_t rast
);
    int n_ht, n_ha, n_hs, n_hbp;
    int n_vt, n_vsl, n_v1, n_v2, n_a1b, n_a1e, n_a2b, n_a2e, n_f2;
    logic n_il, n_neg, n_sd525;
    int s_hs, s_beg, s_ht;

    // Select nominal (unscaled) timing numbers for the code
    always_comb begin : pick_nominal
        n_ht = 858;  n_ha = 720;  n_hs = 62;  n_hbp = 57;
        n_vt = 525;  n_vsl = 3;   n_v1 = 4;   n_v2 = 266;
        n_a1b = 22;  n_a1e = 261; n_a2b = 285; n_a2e = 524;
        n_f2 = 264;  n_il = 1'b1; n_neg = 1'b1; n_sd525 = 1'b1;
        case (ctrl.fmt)
            FMT_576I: begin
                n_ht = 864; n_hs = 63; n_hbp = 69; n_vt = 625;
                n_v1 = 1; n_v2 = 313; n_a1b = 23; n_a1e = 310;
                n_a2b = 336; n_a2e = 623; n_f2 = 313; n_sd525 = 1'b0;
            end
            FMT_720P60, FMT_720P50: begin
                n_ht = (ctrl.fmt == FMT_720P60) ? 1650 : 1980;
                n_ha = 1280; n_hs = 40; n_hbp = 220; n_vt = 750;
                n_vsl = 5; n_v1 = 1; n_v2 = 0; n_a1b = 26; n_a1e = 745;
                n_a2b = 0; n_a2e = 0; n_f2 = 0;
                n_il = 1'b0; n_neg = 1'b0; n_sd525 = 1'b0;
            end
            FMT_1080I60, FMT_1080I50: begin
                n_ht = (ctrl.fmt == FMT_1080I60) ? 2200 : 2640;
                n_ha = 1920; n_hs = 44; n_hbp = 148; n_vt = 1125;
                n_vsl = 5; n_v1 = 1; n_v2 = 563; n_a1b = 21; n_a1e = 560;
                n_a2b = 584; n_a2e = 1123; n_f2 = 563;
                n_neg = 1'b0; n_sd525 = 1'b0;
            end
            FMT_1080P60, FMT_1080P50, FMT_1080P24: begin
                n_ht = (ctrl.fmt == FMT_1080P60) ? 2200 :
                       (ctrl.fmt == FMT_1080P50) ? 2640 : 2750;
                n_ha = 1920; n_hs = 44; n_hbp = 148; n_vt = 1125;
                n_vsl = 5; n_v1 = 1; n_v2 = 0; n_a1b = 42; n_a1e = 1121;
                n_a2b = 0; n_a2e = 0; n_f2 = 0;
                n_il = 1'b0; n_neg = 1'b0; n_sd525 = 1'b0;
            end
            default: ;
        endcase
        if (n_sd525 && ctrl.trs) begin
            n_a1b = 20;  n_a1e = 263;
            n_a2b = 283; n_a2e = 525;
        end
    end

    // Apply horizontal division and pack the geometry record
    always_comb begin : scale_pack
        s_hs  = hscale(n_hs, H_DIV);
        s_beg = s_hs + hscale(n_hbp, H_DIV);
        s_ht  = hscale(n_ht, H_DIV);
        rast.ht         = PIX_W'(s_ht);
        rast.hs_end     = PIX_W'(s_hs);
        rast.act_beg    = PIX_W'(s_beg);
        rast.act_end    = PIX_W'(s_beg + hscale(n_ha, H_DIV));
        rast.half       = PIX_W'(s_ht / 2);
        rast.vt         = LINE_W'(n_vt);
        rast.vs1_beg    = LINE_W'(n_v1);
        rast.vs1_end    = LINE_W'(n_v1 + n_vsl);
        rast.vs2_beg    = LINE_W'(n_v2);
        rast.vs2_end    = LINE_W'(n_v2 + n_vsl);
        rast.a1_beg     = LINE_W'(n_a1b);
        rast.a1_end     = LINE_W'(n_a1e);
        rast.a2_beg     = LINE_W'(n_a2b);
        rast.a2_end     = LINE_W'(n_a2e);
        rast.f2_beg     = LINE_W'(n_f2);
        rast.interlaced = n_il;
        rast.neg_pol    = n_neg;
    end
endmodule

// File: rtl/cea_raster_counter.sv
// Raster counter: pixel and line position plus the per-frame control latch.
// Assumes the geometry input is derived from ctrl_q only.
module cea_raster_counter
    import cea_sync_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  ctrl_t             ctrl_in,
    input  raster_t           rast,
    output logic [PIX_W-1:0]  pix,
    output logic [LINE_W-1:0] line,
    output ctrl_t             ctrl_q
);
    logic line_done;
    logic frame_done;

    // Detect the last pixel and the last line of the raster
    always_comb begin : wrap_detect
        line_done  = (pix >= rast.ht - PIX_W'(1));
        frame_done = line_done && (line >= rast.vt);
    end

    // Advance position; capture controls only at the frame wrap
    always_ff @(posedge clk) begin : advance
        if (!rst_n) begin
            pix    <= '0;
            line   <= LINE_W'(1);
            ctrl_q <= ctrl_in;
        end else if (frame_done) begin
            pix    <= '0;
            line   <= LINE_W'(1);
            ctrl_q <= ctrl_in;
        end else if (line_done) begin
            pix    <= '0;
            line   <= line + LINE_W'(1);
        end else begin
            pix    <= pix + PIX_W'(1);
        end
    end
endmodule

// File: rtl/cea_window_gen.sv
// Window generator: active-high sync, active-window and field terms from position.
// Assumes an interlaced second-field sync never spans the frame wrap.
module cea_window_gen
    import cea_sync_pkg::*;
(
    input  logic [PIX_W-1:0]  pix,
    input  logic [LINE_W-1:0] line,
    input  raster_t           rast,
    output logic              hs_a,
    output logic              vs_a,
    output logic              hact,
    output logic              vact,
    output logic              fld
);
    logic vs_f1;
    logic vs_f2;

    // Horizontal terms
    always_comb begin : horiz
        hs_a = (pix < rast.hs_end);
        hact = (pix >= rast.act_beg) && (pix < rast.act_end);
    end

    // Vertical terms, with the half-line offset for the second field
    always_comb begin : vert
        vs_f1 = (line >= rast.vs1_beg) && (line < rast.vs1_end);
        vs_f2 = rast.interlaced &&
                (((line == rast.vs2_beg) && (pix >= rast.half)) ||
                 ((line > rast.vs2_beg) && (line < rast.vs2_end)) ||
                 ((line == rast.vs2_end) && (pix < rast.half)));
        vs_a  = vs_f1 || vs_f2;
        vact  = ((line >= rast.a1_beg) && (line <= rast.a1_end)) ||
                (rast.interlaced && (line >= rast.a2_beg) && (line <= rast.a2_end));
        fld   = rast.interlaced && (line >= rast.f2_beg);
    end
endmodule

// File: rtl/cea_stat_out.sv
// Status register: selects sync/DE or blanking/field flags, applies polarity.
// Assumes window inputs are active-high.
module cea_stat_out (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cea,
    input  logic       neg_pol,
    input  logic       hs_a,
    input  logic       vs_a,
    input  logic       hact,
    input  logic       vact,
    input  logic       fld,
    output logic [2:0] stat
);
    logic [2:0] stat_d;

    // Choose the output convention
    always_comb begin : select
        if (cea) stat_d = {hact & vact, vs_a ^ neg_pol, hs_a ^ neg_pol};
        else     stat_d = {fld, ~vact, ~hact};
    end

    // Register the status bus
    always_ff @(posedge clk) begin : hold
        if (!rst_n) stat <= 3'b000;
        else        stat <= stat_d;
    end
endmodule

// File: rtl/cea_sync_gen.sv
// Top: selectable sync generator. Inputs are sampled at the frame wrap;
// stat lags the raster position by one clock.
module cea_sync_gen
    import cea_sync_pkg::*;
#(
    parameter int H_DIV = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cea_mode,
    input  logic [FMT_W-1:0] fmt_sel,
    input  logic             trs_follow,
    output logic [2:0]       stat
);
    ctrl_t             ctrl_in;
    ctrl_t             ctrl_q;
    raster_t           rast;
    logic [PIX_W-1:0]  pix_cnt;
    logic [LINE_W-1:0] line_cnt;
    logic              hs_a, vs_a, hact, vact, fld;

    // Bundle the raw controls
    always_comb begin : bundle
        ctrl_in.fmt = fmt_sel;
        ctrl_in.cea = cea_mode;
        ctrl_in.trs = trs_follow;
    end

    cea_fmt_decode #(.H_DIV(H_DIV)) u_dec (
        .ctrl (ctrl_q),
        .rast (rast)
    );

    cea_raster_counter u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .ctrl_in (ctrl_in),
        .rast    (rast),
        .pix     (pix_cnt),
        .line    (line_cnt),
        .ctrl_q  (ctrl_q)
    );

    cea_window_gen u_win (
        .pix  (pix_cnt),
        .line (line_cnt),
        .rast (rast),
        .hs_a (hs_a),
        .vs_a (vs_a),
        .hact (hact),
        .vact (vact),
        .fld  (fld)
    );

    cea_stat_out u_out (
        .clk     (clk),
        .rst_n   (rst_n),
        .cea     (ctrl_q.cea),
        .neg_pol (rast.neg_pol),
        .hs_a    (hs_a),
        .vs_a    (vs_a),
        .hact    (hact),
        .vact    (vact),
        .fld     (fld),
        .stat    (stat)
    );
endmodule

// File: rtl/cea_sync_gen_chk.sv
// Checker for cea_sync_gen: temporal properties on position, controls and stat.
module cea_sync_gen_chk
    import cea_sync_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [2:0]        stat,
    input logic [PIX_W-1:0]  pix,
    input logic [LINE_W-1:0] line,
    input ctrl_t             ctrl_q,
    input raster_t           rast
);
    logic valid_d, cea_d, neg_d, il_d;

    // Track the mode that produced the current stat word
    always_ff @(posedge clk) begin : track
        if (!rst_n) begin
            valid_d <= 1'b0;
            cea_d   <= 1'b0;
            neg_d   <= 1'b0;
            il_d    <= 1'b0;
        end else begin
            valid_d <= 1'b1;
            cea_d   <= ctrl_q.cea;
            neg_d   <= rast.neg_pol;
            il_d    <= rast.interlaced;
        end
    end

    assert_de_excl_sync_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_d && cea_d && stat[2]) |-> (stat[0] == neg_d && stat[1] == neg_d));

    assert_prog_field_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_d && !cea_d && !il_d) |-> !stat[2]);

    assert_pix_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (pix == rast.ht - PIX_W'(1)) |=> (pix == '0));

    assert_pix_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (pix < rast.ht - PIX_W'(1)) |=> (pix == $past(pix) + PIX_W'(1)));

    assert_line_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (line >= LINE_W'(1)) && (line <= rast.vt));

    assert_ctrl_frame_only_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ctrl_q) |-> (pix == '0 && line == LINE_W'(1)));
endmodule

bind cea_sync_gen cea_sync_gen_chk u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .stat   (stat),
    .pix    (pix_cnt),
    .line   (line_cnt),
    .ctrl_q (ctrl_q),
    .rast   (rast)
);

// File: tb/tb_cea_sync_gen.sv
module tb_cea_sync_gen;
    localparam int CLK_PERIOD = 10;
    localparam int HDIV = 32;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cea_mode = 1'b1;
    logic [3:0] fmt_sel = 4'd0;
    logic       trs_follow = 1'b0;
    logic [2:0] stat;

    int n_checks = 0;
    int n_fail = 0;
    bit cmp_en = 0;
    bit done = 0;
    string cur_req = "R10";

    // reference model state
    int m_fmt, m_pix, m_line;
    bit m_cea, m_trs;
    logic [2:0] exp_stat = 3'b000;

    // frame results
    int r_de, r_hs0, r_hs1, r_f, r_viol, r_vs_rise;

    always #(CLK_PERIOD/2) clk = ~clk;

    cea_sync_gen #(.H_DIV(HDIV)) dut (
        .clk(clk), .rst_n(rst_n), .cea_mode(cea_mode),
        .fmt_sel(fmt_sel), .trs_follow(trs_follow), .stat(stat)
    );

    function automatic int sc(input int v);
        return ((v / HDIV) < 1) ? 1 : v / HDIV;
    endfunction

    // Requirement tables R2..R7, R11, R12
    function automatic void geom(input int f, input bit trs,
        output int ht, output int ha, output int hs, output int hbp,
        output int vt, output int vsl, output int v1, output int v2,
        output int a1b, output int a1e, output int a2b, output int a2e,
        output int f2, output bit il, output bit neg);
        int c;
        c = (f > 8) ? 0 : f;
        il = 1; neg = 0; v2 = 0; a2b = 0; a2e = 0; f2 = 0; vsl = 5; v1 = 1;
        ha = 1920; hs = 44; hbp = 148; vt = 1125;
        case (c)
            0: begin ht=858; ha=720; hs=62; hbp=57; vt=525; vsl=3; v1=4; v2=266;
                     neg=1; f2=264;
                     if (trs) begin a1b=20; a1e=263; a2b=283; a2e=525; end
                     else     begin a1b=22; a1e=261; a2b=285; a2e=524; end end
            1: begin ht=864; ha=720; hs=63; hbp=69; vt=625; vsl=3; v2=313;
                     neg=1; f2=313; a1b=23; a1e=310; a2b=336; a2e=623; end
            2, 3: begin ht=(c==2)?1650:1980; ha=1280; hs=40; hbp=220; vt=750;
                     il=0; a1b=26; a1e=745; end
            4, 5: begin ht=(c==4)?2200:2640; v2=563; f2=563;
                     a1b=21; a1e=560; a2b=584; a2e=1123; end
            default: begin ht=(c==6)?2200:(c==7)?2640:2750; il=0;
                     a1b=42; a1e=1121; end
        endcase
    endfunction

    function automatic logic [2:0] model(input int f, input bit cea, input bit trs,
                                         input int p, input int l);
        int ht, ha, hs, hbp, vt, vsl, v1, v2, a1b, a1e, a2b, a2e, f2;
        bit il, neg, hsy, vsy, ha_on, va_on, fl;
        int half;
        geom(f, trs, ht, ha, hs, hbp, vt, vsl, v1, v2, a1b, a1e, a2b, a2e, f2, il, neg);
        half = sc(ht) / 2;
        hsy = p < sc(hs);
        ha_on = (p >= sc(hs) + sc(hbp)) && (p < sc(hs) + sc(hbp) + sc(ha));
        vsy = (l >= v1 && l < v1 + vsl);
        if (il && ((l == v2 && p >= half) || (l > v2 && l < v2 + vsl) ||
                   (l == v2 + vsl && p < half))) vsy = 1;
        va_on = (l >= a1b && l <= a1e) || (il && l >= a2b && l <= a2e);
        fl = il && (l >= f2);
        if (cea) return {ha_on & va_on, vsy ^ neg, hsy ^ neg};
        return {fl, ~va_on, ~ha_on};
    endfunction

    // Cycle-by-cycle reference model
    always @(posedge clk) begin
        int ht, ha, hs, hbp, vt, vsl, v1, v2, a1b, a1e, a2b, a2e, f2;
        bit il, neg;
        if (!rst_n) begin
            m_pix = 0; m_line = 1; m_fmt = fmt_sel; m_cea = cea_mode; m_trs = trs_follow;
            exp_stat = 3'b000;
        end else begin
            exp_stat = model(m_fmt, m_cea, m_trs, m_pix, m_line);
            geom(m_fmt, m_trs, ht, ha, hs, hbp, vt, vsl, v1, v2, a1b, a1e, a2b, a2e, f2, il, neg);
            if (m_pix >= sc(ht) - 1) begin
                m_pix = 0;
                if (m_line >= vt) begin
                    m_line = 1; m_fmt = fmt_sel; m_cea = cea_mode; m_trs = trs_follow;
                end else m_line = m_line + 1;
            end else m_pix = m_pix + 1;
        end
    end

    // Compare on every clock, away from the active edge
    always @(negedge clk) begin
        if (cmp_en && !done) begin
            n_checks++;
            if (stat !== exp_stat) begin
                n_fail++;
                $display("FAIL %s stat actual=%b expected=%b at %0t", cur_req, stat, exp_stat, $time);
            end
        end
    end

    task automatic check_eq(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Run n cycles, gathering counts; apply next-frame controls half-way (R9)
    task automatic run_frame(input int n, input int nf, input bit nc, input bit nt,
                             input logic [1:0] idle);
        bit prev_vs;
        r_de = 0; r_hs0 = 0; r_hs1 = 0; r_f = 0; r_viol = 0; r_vs_rise = -1;
        prev_vs = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (i == n / 2) begin fmt_sel = 4'(nf); cea_mode = nc; trs_follow = nt; end
            if (stat[2]) r_de++;
            if (stat[2]) r_f++;
            if (!stat[0]) r_hs0++; else r_hs1++;
            if (stat[2] && stat[1:0] != idle) r_viol++;
            if (i > 0 && stat[1] && !prev_vs) r_vs_rise = i;
            prev_vs = stat[1];
        end
    endtask

    initial begin
        #(CLK_PERIOD * 190000);
        if (!done) begin
            n_fail++;
            $display("FAIL R10 watchdog actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        cmp_en = 1;
        repeat (3) @(negedge clk);
        check_eq("R10", "stat in reset", int'(stat), 0);
        rst_n = 1'b1;
        // first stat after release: 480i line 1 pixel 0 -> hsync low, vsync idle high
        @(negedge clk);
        check_eq("R10", "first stat", int'(stat), 3'b010);
        cur_req = "R4";
        // frame A: 480i std; window bit raised mid-frame must wait (R9)
        run_frame(26*525 - 1, 0, 1'b1, 1'b1, 2'b11);
        check_eq("R4", "480i std DE cycles", r_de, 480*22);
        check_eq("R9", "mid-frame window change deferred", r_de, 480*22);
        check_eq("R3", "480i active-low hsync cycles", r_hs0 + 1, 525);
        check_eq("R8", "DE with sync", r_viol, 0);
        // frame B: 480i with wider window
        cur_req = "R5";
        run_frame(26*525, 12, 1'b0, 1'b0, 2'b11);
        check_eq("R5", "480i wide DE cycles", r_de, 487*22);
        check_eq("R8", "DE with sync", r_viol, 0);
        // frame C: unused code 12 in flag mode
        cur_req = "R11";
        run_frame(26*525, 1, 1'b1, 1'b1, 2'b11);
        check_eq("R11", "field flag cycles", r_f, 262*26);
        check_eq("R1", "horizontal blank flag cycles", r_hs1, 525*4);
        check_eq("R12", "unused code frame length field", r_f + (263*26), 525*26);
        // frame D: 576i with window bit high (no effect)
        cur_req = "R6";
        run_frame(27*625, 4, 1'b1, 1'b0, 2'b11);
        check_eq("R5", "576i DE unaffected by window bit", r_de, 576*22);
        check_eq("R3", "576i active-low hsync cycles", r_hs0, 625);
        // frame E: 1080i60
        cur_req = "R7";
        run_frame(68*1125, 2, 1'b1, 1'b0, 2'b00);
        check_eq("R6", "1080i DE cycles", r_de, 1080*60);
        check_eq("R3", "1080i active-high hsync cycles", r_hs1, 1125);
        check_eq("R7", "second vsync line", r_vs_rise / 68, 562);
        check_eq("R7", "second vsync half-line pixel", r_vs_rise % 68, 34);
        check_eq("R8", "DE with sync", r_viol, 0);
        // frame F: partial 720p60
        cur_req = "R2";
        run_frame(6000, 3, 1'b1, 1'b0, 2'b00);
        check_eq("R2", "720p DE cycles in first 6000", r_de, ((6000 / 51) - 25) * 40 +
                 ((6000 % 51) > 47 ? 40 : ((6000 % 51) > 7 ? (6000 % 51) - 7 : 0)));
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule